// File: doc/BRIEF.md
# DMA Request Steering Register

This block sits between sixteen peripheral interrupt lines and the rest of the chip. Each channel has one enable bit. While the bit is 0, the peripheral's request passes unchanged to the interrupt controller. While the bit is 1, a rising request becomes a one-cycle start pulse to the DMA engine, and the CPU interrupt is held back. When the engine reports that the transfer is finished, the interrupt is raised. It stays raised until the peripheral drops its request.

The sixteen enable bits are split into two byte lanes on a simple CPU bus. Byte offset 0, at address 0x0000AC, holds channels 7..0. Byte offset 1, at address 0x0000AD, holds channels 15..8. The hardware clears a channel's bit by itself when the byte counter of that channel runs out, or when the peripheral asks to stop. An idle output is true when no channel is enabled, so that software can check it before entering a low-power mode.

Each channel runs a four-state machine:
- PASS: steering off, the request is forwarded.
- ARMED: enabled, waiting for a request edge.
- BUSY: a transfer is running, the interrupt is held back.
- HOLD: the transfer has ended, the interrupt is presented.

The transitions are:
- PASS→ARMED: the enable bit is seen.
- ARMED→PASS: the enable bit is gone.
- ARMED→BUSY: the request rises.
- BUSY→HOLD: done, count-zero or stop.
- HOLD→ARMED or HOLD→PASS: the request goes low. The target depends on the enable bit.

Top module: `dma_steer_top`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all enable bits, returns every channel to PASS, reads back 0x00 from both lanes, and drives all_idle high.
- R2: A write to address 0x0000AC loads bits 7..0 and a write to 0x0000AD loads bits 15..8, leaving the other lane untouched. bus_rdata returns the addressed lane combinationally and 0x00 for any other address. A write to another address changes nothing.
- R3: For a channel whose enable bit is 0 and which is not in HOLD, irq_out equals periph_req in the same cycle, and dma_start stays 0.
- R4: For an enabled channel in ARMED, a 0→1 request gives dma_start high for exactly one cycle while irq_out stays 0. A request that stays high gives no further start. A request already high when the channel is armed gives no start until it falls and rises again.
- R5: After dma_done for a BUSY channel, irq_out for that channel is 1 from the next cycle and stays 1 until periph_req goes low.
- R6: byte_cnt_zero or periph_stop for a channel clears its enable bit at the next edge. For a BUSY channel, the same event also ends the transfer and releases the interrupt as in R5.
- R7: When a hardware clear and a CPU write to the same lane fall in one cycle, the cleared bits become 0. The other bits of that lane take the written value.
- R8: all_idle is 1 exactly when every enable bit is 0. No dma_start is issued while it is 1.
- R9: A change of an enable bit alters the steering of its channel from the cycle after the bit changes. In the cycle directly after the write, the previous steering still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | CPU byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data of the addressed lane |
| periph_req | input | 16 | Peripheral interrupt requests |
| periph_stop | input | 16 | Peripheral stop requests |
| byte_cnt_zero | input | 16 | Byte counter exhausted, per channel |
| dma_done | input | 16 | Transfer finished, from the DMA engine |
| dma_start | output | 16 | One-cycle DMA activation pulses |
| irq_out | output | 16 | Requests to the interrupt controller |
| all_idle | output | 1 | No channel enabled |

## Verification
Two collisions matter most.

The first is a hardware clear meeting a CPU write to the same lane. The bench writes 0x03 to the high lane in the very cycle that channel 9 raises its stop request. It then reads the lane back and expects 0x01: channel 9 cleared, channel 8 set.

The second is the engine's done signal arriving together with count exhaustion. The bench drives both in one cycle on channel 15. It expects the enable bit to read back 0 and the interrupt to rise on the next cycle, and nothing to be lost or doubled.

// File: rtl/dma_steer_pkg.sv
package dma_steer_pkg;

    typedef enum logic [1:0] {
        CH_PASS  = 2'd0,
        CH_ARMED = 2'd1,
        CH_BUSY  = 2'd2,
        CH_HOLD  = 2'd3
    } ch_state_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/dma_steer_regs.sv
module dma_steer_regs
    import dma_steer_pkg::*;
#(
    parameter int             NCH       = 16,
    parameter int             AW        = 24,
    parameter logic [AW-1:0]  BASE_ADDR = 24'h0000AC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [LANE_W-1:0] bus_wdata,
    input  logic [NCH-1:0]    hw_clr,
    output logic [NCH-1:0]    en_bits,
    output logic [LANE_W-1:0] bus_rdata
);

    localparam int NLANES = NCH / LANE_W;

    // one byte lane per group of eight channels
    for (genvar b = 0; b < NLANES; b++) begin : g_lane
        localparam logic [AW-1:0] LANE_ADDR = BASE_ADDR + AW'(b);
        logic [LANE_W-1:0] lane_q;
        logic              lane_sel;

        assign lane_sel = bus_wr && (bus_addr == LANE_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                // hardware clear takes priority over the written value
                lane_q <= (lane_sel ? bus_wdata : lane_q) & ~hw_clr[b*LANE_W +: LANE_W];
            end
        end

        assign en_bits[b*LANE_W +: LANE_W] = lane_q;
    end

    // side-effect-free read path
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NLANES; b++) begin
            if (bus_addr == BASE_ADDR + AW'(b)) begin
                bus_rdata = en_bits[b*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/dma_steer_chan.sv
module dma_steer_chan
    import dma_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic hw_clr,
    input  logic xfer_done,
    output logic start,
    output logic irq
);

    ch_state_e st_q, st_d;
    logic      req_q;
    logic      req_rise;

    assign req_rise = req & ~req_q;

    // state register and request history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_PASS;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            req_q <= req;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_PASS: begin
                if (en) st_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (!en)          st_d = CH_PASS;
                else if (req_rise) st_d = CH_BUSY;
            end
            CH_BUSY: begin
                if (xfer_done || hw_clr) st_d = CH_HOLD;
            end
            CH_HOLD: begin
                if (!req) st_d = en ? CH_ARMED : CH_PASS;
            end
            default: st_d = CH_PASS;
        endcase
    end

    // outputs
    always_comb begin
        start = 1'b0;
        irq   = 1'b0;
        unique case (st_q)
            CH_PASS:  irq   = req;
            CH_ARMED: start = en & req_rise;
            CH_BUSY:  irq   = 1'b0;
            CH_HOLD:  irq   = 1'b1;
            default:  irq   = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_steer_top.sv
module dma_steer_top
    import dma_steer_pkg::*;
#(
    parameter int             NCH       = 16,
    parameter int             AW        = 24,
    parameter logic [AW-1:0]  BASE_ADDR = 24'h0000AC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    periph_req,
    input  logic [NCH-1:0]    periph_stop,
    input  logic [NCH-1:0]    byte_cnt_zero,
    input  logic [NCH-1:0]    dma_done,
    output logic [NCH-1:0]    dma_start,
    output logic [NCH-1:0]    irq_out,
    output logic              all_idle
);

    logic [NCH-1:0] en_vec;
    logic [NCH-1:0] hw_clr;

    assign hw_clr = periph_stop | byte_cnt_zero;

    dma_steer_regs #(
        .NCH       (NCH),
        .AW        (AW),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .hw_clr    (hw_clr),
        .en_bits   (en_vec),
        .bus_rdata (bus_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_steer_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_vec[c]),
            .req       (periph_req[c]),
            .hw_clr    (hw_clr[c]),
            .xfer_done (dma_done[c]),
            .start     (dma_start[c]),
            .irq       (irq_out[c])
        );
    end

    assign all_idle = ~|en_vec;

endmodule

// File: rtl/dma_steer_chk.sv
module dma_steer_chk #(
    parameter int             NCH       = 16,
    parameter int             AW        = 24,
    parameter logic [AW-1:0]  BASE_ADDR = 24'h0000AC
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_wr,
    input logic [NCH-1:0] periph_stop,
    input logic [NCH-1:0] byte_cnt_zero,
    input logic [NCH-1:0] dma_start,
    input logic [NCH-1:0] irq_out,
    input logic           all_idle,
    input logic [NCH-1:0] en_vec
);

    localparam logic [NCH-1:0] LO_MASK = NCH'(8'hFF);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start != '0) |=> ((dma_start & $past(dma_start)) == '0)); // R4

    AST_START_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start != '0) |-> ((dma_start & irq_out) == '0)); // R4

    AST_HWCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_stop | byte_cnt_zero) != '0)
        |=> ((en_vec & $past(periph_stop | byte_cnt_zero)) == '0)); // R7

    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        all_idle |-> (dma_start == '0)); // R8

    AST_LANE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == BASE_ADDR) && (((periph_stop | byte_cnt_zero) & ~LO_MASK) == '0))
        |=> ((en_vec & ~LO_MASK) == ($past(en_vec) & ~LO_MASK))); // R2

endmodule

bind dma_steer_top dma_steer_chk #(
    .NCH       (NCH),
    .AW        (AW),
    .BASE_ADDR (BASE_ADDR)
) u_chk (.*);

// File: tb/sim_dma_steer_top.sv
`timescale 1ns/1ps
module sim_dma_steer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] periph_req = '0;
    logic [15:0] periph_stop = '0;
    logic [15:0] byte_cnt_zero = '0;
    logic [15:0] dma_done = '0;
    logic [15:0] dma_start;
    logic [15:0] irq_out;
    logic        all_idle;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_steer_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .periph_req    (periph_req),
        .periph_stop   (periph_stop),
        .byte_cnt_zero (byte_cnt_zero),
        .dma_done      (dma_done),
        .dma_start     (dma_start),
        .irq_out       (irq_out),
        .all_idle      (all_idle)
    );

    // fields: wr, addr, wdata, req, stop, cnt0, done | exp start, exp irq, exp rdata, exp idle
    localparam int NV = 23;
    localparam logic [121:0] TAB [NV] = '{
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0001,8'h00,1'b1}, // R3 pass-through
        {1'b1,8'hAC,8'h01,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,8'h00,1'b1}, // enable ch0
        {1'b0,8'hAD,8'h00,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,8'h00,1'b0},
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0001,16'h0000,8'h01,1'b0}, // R4 start
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,8'h01,1'b0}, // R4 no repeat
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0001, 16'h0000,16'h0000,8'h01,1'b0}, // done
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0001,8'h01,1'b0}, // R5 held irq
        {1'b0,8'hAC,8'h00,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0001,8'h01,1'b0}, // R5 req low, still HOLD
        {1'b0,8'hAC,8'h00,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,8'h01,1'b0}, // re-armed
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0001,16'h0000,8'h01,1'b0}, // R4 second start
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0001,16'h0000, 16'h0000,16'h0000,8'h01,1'b0}, // R6 count zero
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0001,8'h00,1'b1}, // R6 cleared, irq
        {1'b0,8'hAC,8'h00,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0001,8'h00,1'b1},
        {1'b0,8'hAC,8'h00,16'h0001,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0001,8'h00,1'b1}, // R3 back to pass
        {1'b1,8'hAD,8'h02,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,8'h00,1'b1}, // enable ch9
        {1'b0,8'hAD,8'h00,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,8'h02,1'b0}, // R2 high lane
        {1'b0,8'hAD,8'h00,16'h0200,16'h0000,16'h0000,16'h0000, 16'h0200,16'h0000,8'h02,1'b0},
        {1'b1,8'hAD,8'h03,16'h0200,16'h0200,16'h0000,16'h0000, 16'h0000,16'h0000,8'h02,1'b0}, // R7 collision
        {1'b0,8'hAD,8'h00,16'h0200,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0200,8'h01,1'b0}, // R7 result, R6 stop
        {1'b0,8'hAC,8'h00,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0200,8'h00,1'b0},
        {1'b0,8'hAC,8'h00,16'h0300,16'h0000,16'h0000,16'h0000, 16'h0100,16'h0200,8'h00,1'b0}, // ch8 start, ch9 pass
        {1'b0,8'hAD,8'h00,16'h0300,16'h0100,16'h0000,16'h0000, 16'h0000,16'h0200,8'h01,1'b0}, // R6 stop ch8
        {1'b0,8'hAD,8'h00,16'h0300,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0300,8'h00,1'b1}  // R8 idle
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] a, input logic [7:0] wd,
                         input logic [15:0] rq, input logic [15:0] st,
                         input logic [15:0] cz, input logic [15:0] dn);
        @(negedge clk);
        bus_wr        = wr;
        bus_addr      = {16'h0000, a};
        bus_wdata     = wd;
        periph_req    = rq;
        periph_stop   = st;
        byte_cnt_zero = cz;
        dma_done      = dn;
        #2;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #2;
        bus_addr = 24'h0000AC;
        #1;
        chk("R1 rdata lo", {24'h0, bus_rdata}, 32'h0);
        chk("R1 idle", {31'h0, all_idle}, 32'h1);
        chk("R1 start", {16'h0, dma_start}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [121:0] v;
            v = TAB[i];
            drive(v[121], v[120:113], v[112:105], v[104:89], v[88:73], v[72:57], v[56:41]);
            chk("R4 start", {16'h0, dma_start}, {16'h0, v[40:25]});
            chk("R5 irq",   {16'h0, irq_out},   {16'h0, v[24:9]});
            chk("R2 rdata", {24'h0, bus_rdata}, {24'h0, v[8:1]});
            chk("R8 idle",  {31'h0, all_idle},  {31'h0, v[0]});
        end

        // settle: release requests
        drive(1'b0, 8'hAC, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0);
        drive(1'b0, 8'hAC, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R3 quiet irq", {16'h0, irq_out}, 32'h0);

        // R9 / R4: enable ch15 while its request is already high
        drive(1'b1, 8'hAD, 8'h80, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R3 irq before enable", {16'h0, irq_out}, 32'h8000);
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R9 old steering one cycle", {16'h0, irq_out}, 32'h8000);
        chk("R9 no start", {16'h0, dma_start}, 32'h0);
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R9 steered irq", {16'h0, irq_out}, 32'h0);
        chk("R4 high level no start", {16'h0, dma_start}, 32'h0);
        drive(1'b0, 8'hAD, 8'h00, 16'h0000, 16'h0, 16'h0, 16'h0);
        chk("R4 low no start", {16'h0, dma_start}, 32'h0);
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R4 rise start", {16'h0, dma_start}, 32'h8000);
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R4 one pulse", {16'h0, dma_start}, 32'h0);

        // R2: write to an unmapped address
        drive(1'b1, 8'hAE, 8'hFF, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R2 unmapped read", {24'h0, bus_rdata}, 32'h0);
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R2 high lane kept", {24'h0, bus_rdata}, 32'h80);
        drive(1'b0, 8'hAC, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R2 low lane kept", {24'h0, bus_rdata}, 32'h0);

        // R6: done and count exhaustion together
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h8000, 16'h8000);
        chk("R5 busy irq low", {16'h0, irq_out}, 32'h0);
        drive(1'b0, 8'hAD, 8'h00, 16'h8000, 16'h0, 16'h0, 16'h0);
        chk("R6 bit cleared", {24'h0, bus_rdata}, 32'h0);
        chk("R6 irq released", {16'h0, irq_out}, 32'h8000);
        chk("R8 idle again", {31'h0, all_idle}, 32'h1);

        // R1: reset mid-operation
        drive(1'b1, 8'hAC, 8'hFF, 16'h0, 16'h0, 16'h0, 16'h0);
        drive(1'b0, 8'hAC, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R2 low lane all set", {24'h0, bus_rdata}, 32'hFF);
        chk("R8 not idle", {31'h0, all_idle}, 32'h0);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", {24'h0, bus_rdata}, 32'h0);
        chk("R1 idle after reset", {31'h0, all_idle}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 8'hAC, 8'h00, 16'h0001, 16'h0, 16'h0, 16'h0);
        chk("R1 pass after reset", {16'h0, irq_out}, 32'h0001);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule